// File: doc/BRIEF.md
# SPI Clock Divisor Setting Calculator

This block converts a parent clock rate and a requested serial clock rate into the packed setting word for a two-stage serial clock divider. The first stage is a linear prescaler from 1 to 32. The second stage is a power-of-two divider from 1/1 to 1/32. The block first forms the required ratio, which is the parent rate divided by the target rate and rounded up. It then picks a starting power and walks the prescaler down by halving until the prescaler fits. The resulting word is presented together with write strobes for the transmit and receive clock setting registers.

A request is launched with a one-cycle start strobe, and the rate and mode inputs are captured at that point. The ratio comes from a sequential restoring divider that produces one quotient bit per cycle. Each halving step then takes one cycle. If either rate is zero, the request finishes at once with an error flag and no write. If the ratio is above 1024, the divider is clamped to its largest setting and a separate flag is raised. The packed word can never spill into the register bits above the prescaler field.

Top module: `spi_clkdiv_calc`

## Requirements
- R1: The ratio used is ceil(parent_rate_i / target_rate_i), computed over the full input width. A target above the parent therefore gives a ratio of 1.
- R2: The search starts at power min_pow_i (0 or 1). With a start power of 0 and a ratio from 3 to 32, the power is raised to 1. Power 0 (encoding 3'b111) is only ever produced with a prescaler of 1 or 2.
- R3: word_o carries the power encoding in bits 2:0 and (prescaler − 1) in bits 12:8. Bits 15:13 and 7:3 are always zero. The power encodings are 0→3'b111, 1→3'b000, 2→3'b001, 3→3'b010, 4→3'b011 and 5→3'b100.
- R4: The initial prescaler is (ratio+1)>>1 at power 1 and the ratio itself at power 0. While the prescaler exceeds 32, it becomes (prescaler+1)>>1 and the power rises by one, one step per cycle.
- R5: A ratio above 1024 yields power 5 with prescaler 32 (word 0x1F04) and sets err_low_o. A ratio of exactly 1024 gives the same word without the flag.
- R6: If either rate is zero, there is no tx_wr_o or rx_wr_o pulse, err_zero_o is set, and done_o still pulses.
- R7: Every successful request produces exactly one tx_wr_o pulse. rx_wr_o pulses in the same cycle, carrying the same word, unless tx_only_i was high at start.
- R8: done_o is high for exactly one cycle, in the cycle right after the write strobe. A start_i that arrives before done_o is ignored, and the inputs are sampled only when start is accepted.
- R9: After reset, word_o, all strobes and both error flags are zero.
- R10: The error flags hold their values after done_o until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a calculation (ignored while busy) |
| parent_rate_i | input | RATE_W | Parent clock rate |
| target_rate_i | input | RATE_W | Requested serial clock rate |
| min_pow_i | input | 1 | Minimum power-of-two stage (0 or 1) |
| tx_only_i | input | 1 | Transmit-required mode: skip the receive register write |
| word_o | output | 16 | Packed clock setting word, held after the write |
| tx_wr_o | output | 1 | Write strobe for the transmit clock setting register |
| rx_wr_o | output | 1 | Write strobe for the receive clock setting register |
| done_o | output | 1 | One-cycle completion pulse |
| err_zero_o | output | 1 | A rate was zero; no write happened |
| err_low_o | output | 1 | Ratio above 1024; result clamped |

## Verification
A wrong remainder or quotient bit in the divider shows up as a word that is one prescaler code off at the single tx_wr_o pulse. This happens about RATE_W cycles after start, so each vector uses a ratio that lies just above or just below a rounding boundary. A halving loop that stops early or late leaves the prescaler above 32 or the power off by one. Either fault is visible in word_o in the same write cycle. Sequencing faults in the controller, such as a missing done pulse, a write during the zero-rate path, or a start accepted while busy, appear within a cycle of the strobe. The bench counts these pulses for every request.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned PRESC_MAX = 32;
  localparam int unsigned POW_MAX   = 5;
  localparam int unsigned RATIO_CAP = PRESC_MAX << POW_MAX;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned PRESC_LSB = 8;
  localparam int unsigned PRESC_W   = $clog2(PRESC_MAX);
  localparam int unsigned POW_W     = 3;
  localparam int unsigned CNT_W     = $clog2(RATIO_CAP) + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_WR, ST_FIN} ctl_state_e;

  // power-of-two stage field code; power 0 sits at the top code
  function automatic logic [POW_W-1:0] pow_enc(input logic [POW_W-1:0] p);
    logic [POW_W-1:0] e;
    case (p)
      3'd0:    e = 3'b111;
      3'd1:    e = 3'b000;
      3'd2:    e = 3'b001;
      3'd3:    e = 3'b010;
      3'd4:    e = 3'b011;
      default: e = 3'b100;
    endcase
    return e;
  endfunction
endpackage

// File: rtl/clkdiv_ceil_div.sv
module clkdiv_ceil_div #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         done_o,
  output logic [W-1:0] ratio_o
);
  localparam int unsigned CW = $clog2(W) + 1;

  logic [W:0]    rem_q, sh, rem_n;
  logic [W-1:0]  quo_q, den_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q, ge;

  always_comb begin
    sh    = {rem_q[W-1:0], quo_q[W-1]};
    ge    = sh >= {1'b0, den_q};
    rem_n = ge ? sh - {1'b0, den_q} : sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0; quo_q <= '0; den_q <= '0;
      cnt_q <= '0; run_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rem_q <= '0;
        quo_q <= num_i;
        den_q <= den_i;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= rem_n;
        quo_q <= {quo_q[W-2:0], ge};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(W - 1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o  = done_q;
  // round up; no wrap since a full quotient implies zero remainder
  assign ratio_o = quo_q + W'(|rem_q);

  p_rem_below_den_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (rem_q < {1'b0, den_q}));
endmodule

// File: rtl/clkdiv_presc_search.sv
module clkdiv_presc_search
  import clkdiv_pkg::*;
#(
  parameter int unsigned RATIO_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               min_pow_i,
  output logic               done_o,
  output logic [POW_W-1:0]   pow_o,
  output logic [PRESC_W-1:0] presc_m1_o,
  output logic               clamp_o
);
  logic [CNT_W-1:0] presc_q, r_small, presc_init;
  logic [POW_W-1:0] pow_q;
  logic             run_q, clamp_q, over, low_band, pow_start, step;

  always_comb begin
    over       = ratio_i > RATIO_W'(RATIO_CAP);
    low_band   = (ratio_i >= RATIO_W'(3)) && (ratio_i <= RATIO_W'(PRESC_MAX));
    pow_start  = min_pow_i | low_band;
    r_small    = ratio_i[CNT_W-1:0];
    presc_init = pow_start ? ((r_small + CNT_W'(1)) >> 1) : r_small;
    step       = run_q && (presc_q > CNT_W'(PRESC_MAX));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0; pow_q <= '0; run_q <= 1'b0; clamp_q <= 1'b0;
    end else if (start_i) begin
      run_q <= 1'b1;
      if (over) begin
        pow_q   <= POW_W'(POW_MAX);
        presc_q <= CNT_W'(PRESC_MAX);
        clamp_q <= 1'b1;
      end else begin
        pow_q   <= {{(POW_W-1){1'b0}}, pow_start};
        presc_q <= presc_init;
        clamp_q <= 1'b0;
      end
    end else if (run_q) begin
      if (step) begin
        presc_q <= (presc_q + CNT_W'(1)) >> 1;
        pow_q   <= pow_q + 1'b1;
      end else begin
        run_q <= 1'b0;
      end
    end
  end

  assign done_o     = run_q && !step;
  assign pow_o      = pow_q;
  assign presc_m1_o = PRESC_W'(presc_q - CNT_W'(1));
  assign clamp_o    = clamp_q;

  p_halve_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !start_i) |=> (pow_q == $past(pow_q) + 3'd1));
  p_pow_cap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (pow_q <= POW_W'(POW_MAX)));
  p_presc_fit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (presc_q >= CNT_W'(1) && presc_q <= CNT_W'(PRESC_MAX)));
endmodule

// File: rtl/spi_clkdiv_calc.sv
module spi_clkdiv_calc
  import clkdiv_pkg::*;
#(
  parameter int unsigned RATE_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RATE_W-1:0] parent_rate_i,
  input  logic [RATE_W-1:0] target_rate_i,
  input  logic              min_pow_i,
  input  logic              tx_only_i,
  output logic [15:0]       word_o,
  output logic              tx_wr_o,
  output logic              rx_wr_o,
  output logic              done_o,
  output logic              err_zero_o,
  output logic              err_low_o
);
  ctl_state_e          state_q;
  logic                accept, bad_rate, div_done, srch_done, clamp;
  logic                min_pow_q, tx_only_q, err_zero_q, err_low_q;
  logic [RATE_W-1:0]   ratio;
  logic [POW_W-1:0]    pow;
  logic [PRESC_W-1:0]  presc_m1;
  logic [WORD_W-1:0]   word_q, word_n;

  assign accept   = (state_q == ST_IDLE) && start_i;
  assign bad_rate = (parent_rate_i == '0) || (target_rate_i == '0);

  clkdiv_ceil_div #(.W(RATE_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept && !bad_rate),
    .num_i   (parent_rate_i),
    .den_i   (target_rate_i),
    .done_o  (div_done),
    .ratio_o (ratio)
  );

  clkdiv_presc_search #(.RATIO_W(RATE_W)) u_search (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_done),
    .ratio_i    (ratio),
    .min_pow_i  (min_pow_q),
    .done_o     (srch_done),
    .pow_o      (pow),
    .presc_m1_o (presc_m1),
    .clamp_o    (clamp)
  );

  always_comb begin
    word_n = '0;
    word_n[PRESC_LSB +: PRESC_W] = presc_m1;
    word_n[POW_W-1:0]            = pow_enc(pow);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      min_pow_q  <= 1'b0;
      tx_only_q  <= 1'b0;
      err_zero_q <= 1'b0;
      err_low_q  <= 1'b0;
      word_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          min_pow_q  <= min_pow_i;
          tx_only_q  <= tx_only_i;
          err_zero_q <= bad_rate;
          err_low_q  <= 1'b0;
          state_q    <= bad_rate ? ST_FIN : ST_BUSY;
        end
        ST_BUSY: if (srch_done) begin
          word_q    <= word_n;
          err_low_q <= clamp;
          state_q   <= ST_WR;
        end
        ST_WR:   state_q <= ST_FIN;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign word_o     = word_q;
  assign tx_wr_o    = (state_q == ST_WR);
  assign rx_wr_o    = (state_q == ST_WR) && !tx_only_q;
  assign done_o     = (state_q == ST_FIN);
  assign err_zero_o = err_zero_q;
  assign err_low_o  = err_low_q;

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr_o |-> (word_o[15:13] == 3'b0 && word_o[7:3] == 5'b0));
  p_div1_presc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wr_o && word_o[2:0] == 3'b111) |-> (word_o[12:9] == 4'b0));
  p_rx_with_tx_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_wr_o |-> tx_wr_o);
  p_done_after_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr_o |=> done_o);
  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_zero_no_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_zero_o |-> !tx_wr_o);
  p_word_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tx_wr_o) && !tx_wr_o |-> $stable(word_o));
endmodule

// File: tb/tb_spi_clkdiv_calc.sv
module tb_spi_clkdiv_calc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] prate = '0, trate = '0;
  logic        min_pow = 1'b0, tx_only = 1'b0;
  logic [15:0] word;
  logic        tx_wr, rx_wr, done, err_zero, err_low;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  spi_clkdiv_calc #(.RATE_W(32)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .parent_rate_i(prate), .target_rate_i(trate),
    .min_pow_i(min_pow), .tx_only_i(tx_only),
    .word_o(word), .tx_wr_o(tx_wr), .rx_wr_o(rx_wr), .done_o(done),
    .err_zero_o(err_zero), .err_low_o(err_low)
  );

  localparam int NV = 16;
  // parent, target, min power, tx-only, expected word, expected rate-too-low
  localparam logic [31:0] VP [NV] = '{50, 99, 100, 101, 320, 330, 1000, 1000,
                                      1024, 33333333, 650, 32'hFFFF_FFFF, 1000, 4, 2000, 5000};
  localparam logic [31:0] VT [NV] = '{50, 50, 50, 50, 10, 10, 10, 10,
                                      1, 10000, 10, 1, 1, 4000, 10, 10};
  localparam logic        VM [NV] = '{0, 0, 1, 0, 0, 0, 1, 0, 1, 1, 1, 0, 0, 1, 1, 1};
  localparam logic        VX [NV] = '{0, 1, 0, 0, 1, 0, 0, 1, 0, 0, 1, 0, 0, 1, 0, 0};
  localparam logic [15:0] VW [NV] = '{16'h0007, 16'h0107, 16'h0000, 16'h0100,
                                      16'h0F00, 16'h1000, 16'h1801, 16'h1801,
                                      16'h1F04, 16'h1F04, 16'h1001, 16'h1F04,
                                      16'h1F04, 16'h0000, 16'h1802, 16'h1F03};
  localparam logic        VL [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0};

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic launch(input logic [31:0] p, input logic [31:0] t,
                        input logic m, input logic x);
    @(negedge clk);
    prate = p; trate = t; min_pow = m; tx_only = x; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  int wr_n, rx_n, done_n, wr_cyc, done_cyc, got_word, got_low, got_zero, rx_word;

  task automatic collect();
    int tail;
    wr_n = 0; rx_n = 0; done_n = 0; wr_cyc = -10; done_cyc = -20;
    got_word = 0; got_low = 0; got_zero = 0; rx_word = 0; tail = -1;
    for (int cyc = 0; cyc < 300; cyc++) begin
      if (tx_wr) begin wr_n++; wr_cyc = cyc; got_word = int'(word); end
      if (rx_wr) begin rx_n++; rx_word = int'(word); end
      if (done) begin
        done_n++; done_cyc = cyc;
        got_low = int'(err_low); got_zero = int'(err_zero);
        tail = 3;
      end
      if (tail == 0) break;
      if (tail > 0) tail--;
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL R8 watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(word == 16'h0 && !tx_wr && !rx_wr && !done && !err_zero && !err_low,
        "R9", "reset outputs", int'({word, tx_wr, rx_wr, done, err_zero, err_low}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      launch(VP[i], VT[i], VM[i], VX[i]);
      collect();
      chk(got_word == int'(VW[i]), "R1/R4", $sformatf("word vec %0d", i), got_word, int'(VW[i]));
      chk(got_word[15:13] == 3'b0 && got_word[7:3] == 5'b0, "R3", "spare bits", got_word, int'(VW[i]));
      if (got_word[2:0] == 3'b111)
        chk(got_word[12:9] == 4'b0, "R2", "power 0 prescaler", got_word, 0);
      chk(got_low == int'(VL[i]), "R5", $sformatf("rate-too-low vec %0d", i), got_low, int'(VL[i]));
      chk(wr_n == 1, "R7", "tx strobe count", wr_n, 1);
      chk(rx_n == (VX[i] ? 0 : 1), "R7", "rx strobe count", rx_n, VX[i] ? 0 : 1);
      if (!VX[i]) chk(rx_word == got_word, "R7", "rx word", rx_word, got_word);
      chk(done_n == 1 && done_cyc == wr_cyc + 1, "R8", "done timing", done_cyc, wr_cyc + 1);
      chk(got_zero == 0, "R6", "zero flag on valid rates", got_zero, 0);
      // R10: flags held after done
      chk(int'(err_low) == int'(VL[i]), "R10", "flag held", int'(err_low), int'(VL[i]));
    end

    // R6: zero target, then zero parent
    launch(32'd1000, 32'd0, 1'b0, 1'b0);
    collect();
    chk(wr_n == 0 && rx_n == 0, "R6", "no write on zero target", wr_n + rx_n, 0);
    chk(got_zero == 1 && done_n == 1, "R6", "zero flag", got_zero, 1);
    chk(word == 16'h1F03, "R6", "word untouched", int'(word), 16'h1F03);
    launch(32'd0, 32'd7, 1'b1, 1'b0);
    collect();
    chk(wr_n == 0 && got_zero == 1, "R6", "zero parent", got_zero, 1);
    chk(err_zero == 1'b1, "R10", "zero flag held", int'(err_zero), 1);

    // R10: next accepted start clears flags
    launch(32'd1000, 32'd10, 1'b1, 1'b0);
    chk(err_zero == 1'b0 && err_low == 1'b0, "R10", "flags cleared on start",
        int'({err_zero, err_low}), 0);
    collect();
    chk(got_word == 16'h1801, "R1", "after clear", got_word, 16'h1801);

    // R8: start while busy is ignored; first request completes
    launch(32'd2000, 32'd10, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    prate = 32'd50; trate = 32'd0; min_pow = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    collect();
    chk(got_word == 16'h1802 && got_zero == 0, "R8", "busy start ignored", got_word, 16'h1802);
    chk(wr_n == 1 && done_n == 1, "R8", "single completion", wr_n + done_n, 2);
    repeat (5) @(negedge clk);
    chk(!done && !tx_wr, "R8", "no second run", int'({done, tx_wr}), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule